// File: doc/BRIEF.md
# Register Rename Table with Free List

This block assigns physical registers to the architectural destination registers of an out-of-order core. A mapping table holds, for every architectural register, the physical tag that currently stands for it. A rename request names one architectural register. The block answers in the same cycle with a freshly allocated physical tag and the tag it displaces. The displaced tag travels with the instruction and comes back on the release port once the instruction retires. A FIFO of unused physical tags supplies the new tags and takes the released ones back.

One architectural register is wired to zero. It is never renamed: a request for it takes nothing from the free list, leaves the table alone and returns its fixed mapping. Source operands are resolved by combinational lookup ports that read the table as it stands at the start of the cycle. When a tag is needed and none is free, the stall output rises and nothing changes.

Top module: `rn_rename_core`

## Requirements
- R1: After reset, a lookup of architectural register i returns physical tag i for every i.
- R2: After reset the free list holds tags NUM_ARCH to NUM_PHYS-1, so the first non-zero renames receive those tags in ascending order.
- R3: An accepted rename of a non-zero register returns as previous tag the mapping held before the request and as new tag the free-list head. From the next cycle on, a lookup of that register returns the new tag.
- R4: A rename of register ZERO_ARCH (default 0) returns ZERO_ARCH as both new and previous tag, consumes no free tag and leaves the table unchanged.
- R5: While the free list is empty, a non-zero rename raises stall in the same cycle and changes neither the table nor the free list. A release in that same cycle does not clear the stall.
- R6: A released tag joins the tail of the free list and is handed out again in FIFO order.
- R7: A release of physical tag ZERO_ARCH is ignored and that tag is never handed out.
- R8: A lookup in the same cycle as a rename of the same register returns the mapping from before the rename.
- R9: A rename and a release in the same cycle leave the number of free tags unchanged.
- R10: A rename of the zero register never stalls, even when the free list is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid_i | input | 1 | Rename request this cycle |
| ren_arch_i | input | AW | Architectural destination of the request |
| ren_stall_o | output | 1 | Request cannot be served (no free tag) |
| ren_new_tag_o | output | TW | Newly assigned physical tag |
| ren_prev_tag_o | output | TW | Physical tag displaced by the rename |
| src_arch_i | input | NUM_SRC*AW | Packed architectural source indices |
| src_tag_o | output | NUM_SRC*TW | Packed physical tags of the sources |
| rel_valid_i | input | 1 | Release a retired physical tag |
| rel_tag_i | input | TW | Tag being released |

## Verification
The assertions check on every cycle that the free list never pops when empty and never pushes when full, that a simultaneous pop and push keep its occupancy, that an allocated tag is neither the zero tag nor the register's current mapping, that the zero register always maps to itself, and that a table write is visible the next cycle. Only the bench's scenarios show the FIFO order of the initial and released tags, that a stalled request leaves everything untouched, that a released zero tag never reappears, and that lookups see the table from before a same-cycle rename. A behavioural model with a queue and an array is compared against every output on every clock, through directed sequences and a long run of random renames and releases.

// File: rtl/rn_pkg.sv
package rn_pkg;

  // Advance a circular pointer over a store of the given depth.
  function automatic int unsigned ptr_wrap(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of optional pop and push.
  function automatic int unsigned occ_next(input int unsigned occ, input bit pop, input bit push);
    int unsigned r;
    r = occ;
    if (push) r = r + 1;
    if (pop)  r = r - 1;
    return r;
  endfunction

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH  = 16,
  parameter int TW        = 5,
  parameter int NUM_SRC   = 2,
  parameter int ZERO_ARCH = 0,
  localparam int AW = $clog2(NUM_ARCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_idx_i,
  input  logic [TW-1:0]         wr_tag_i,
  input  logic [AW-1:0]         rd_idx_i,
  output logic [TW-1:0]         rd_tag_o,
  input  logic [NUM_SRC*AW-1:0] src_idx_i,
  output logic [NUM_SRC*TW-1:0] src_tag_o
);

  logic [TW-1:0] map_q [NUM_ARCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= TW'(i);
    end else if (wr_en_i) begin
      map_q[wr_idx_i] <= wr_tag_i;
    end
  end

  assign rd_tag_o = map_q[rd_idx_i];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign src_tag_o[s*TW +: TW] = map_q[src_idx_i[s*AW +: AW]];
  end

  AST_ZERO_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    map_q[ZERO_ARCH] == TW'(ZERO_ARCH)); // R4

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> map_q[$past(wr_idx_i)] == $past(wr_tag_i)); // R3

endmodule

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 32,
  parameter int TW       = 5,
  localparam int DEPTH   = NUM_PHYS - NUM_ARCH,
  localparam int PW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_i,
  input  logic          push_i,
  input  logic [TW-1:0] push_tag_i,
  output logic [TW-1:0] head_tag_o,
  output logic          empty_o
);

  logic [TW-1:0] slot_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] occ_q;
  logic          full;
  logic          pop_ok, push_ok;

  assign empty_o    = (occ_q == '0);
  assign full       = (occ_q == CW'(DEPTH));
  assign pop_ok     = pop_i & ~empty_o;
  assign push_ok    = push_i & (~full | pop_ok);
  assign head_tag_o = slot_q[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= TW'(NUM_ARCH + i);
      rd_q  <= '0;
      wr_q  <= '0;
      occ_q <= CW'(DEPTH);
    end else begin
      if (push_ok) begin
        slot_q[wr_q] <= push_tag_i;
        wr_q <= PW'(rn_pkg::ptr_wrap(int'(wr_q), DEPTH));
      end
      if (pop_ok) rd_q <= PW'(rn_pkg::ptr_wrap(int'(rd_q), DEPTH));
      occ_q <= CW'(rn_pkg::occ_next(int'(occ_q), pop_ok, push_ok));
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (!full || pop_i)); // R6

  AST_OCC_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && push_i && !empty_o) |=> occ_q == $past(occ_q)); // R9

endmodule

// File: rtl/rn_rename_core.sv
module rn_rename_core #(
  parameter int NUM_ARCH  = 16,
  parameter int NUM_PHYS  = 32,
  parameter int ZERO_ARCH = 0,
  parameter int NUM_SRC   = 2,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int TW = $clog2(NUM_PHYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ren_valid_i,
  input  logic [AW-1:0]         ren_arch_i,
  output logic                  ren_stall_o,
  output logic [TW-1:0]         ren_new_tag_o,
  output logic [TW-1:0]         ren_prev_tag_o,
  input  logic [NUM_SRC*AW-1:0] src_arch_i,
  output logic [NUM_SRC*TW-1:0] src_tag_o,
  input  logic                  rel_valid_i,
  input  logic [TW-1:0]         rel_tag_i
);

  localparam logic [AW-1:0] ZERO_IDX = AW'(ZERO_ARCH);
  localparam logic [TW-1:0] ZERO_TAG = TW'(ZERO_ARCH);

  // Named internal events, used by the assertions below.
  logic          ren_is_zero;
  logic          need_alloc;
  logic          fl_empty;
  logic          do_pop;
  logic          do_push;
  logic [TW-1:0] fl_head;
  logic [TW-1:0] cur_tag;

  assign ren_is_zero = (ren_arch_i == ZERO_IDX);
  assign need_alloc  = ren_valid_i & ~ren_is_zero;
  assign ren_stall_o = need_alloc & fl_empty;
  assign do_pop      = need_alloc & ~fl_empty;
  assign do_push     = rel_valid_i & (rel_tag_i != ZERO_TAG);

  assign ren_prev_tag_o = cur_tag;
  assign ren_new_tag_o  = ren_is_zero ? cur_tag : fl_head;

  rn_map_table #(
    .NUM_ARCH (NUM_ARCH),
    .TW       (TW),
    .NUM_SRC  (NUM_SRC),
    .ZERO_ARCH(ZERO_ARCH)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (do_pop),
    .wr_idx_i (ren_arch_i),
    .wr_tag_i (fl_head),
    .rd_idx_i (ren_arch_i),
    .rd_tag_o (cur_tag),
    .src_idx_i(src_arch_i),
    .src_tag_o(src_tag_o)
  );

  rn_freelist #(
    .NUM_ARCH(NUM_ARCH),
    .NUM_PHYS(NUM_PHYS),
    .TW      (TW)
  ) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop_i     (do_pop),
    .push_i    (do_push),
    .push_tag_i(rel_tag_i),
    .head_tag_o(fl_head),
    .empty_o   (fl_empty)
  );

  AST_ZERO_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid_i && ren_is_zero) |-> (ren_new_tag_o == ZERO_TAG && ren_prev_tag_o == ZERO_TAG)); // R4

  AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid_i && ren_is_zero) |-> !ren_stall_o); // R10

  AST_ALLOC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |-> ren_new_tag_o != ZERO_TAG); // R7

  AST_ALLOC_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |-> ren_new_tag_o != ren_prev_tag_o); // R3

endmodule

// File: tb/sim_rn_rename_core.sv
module sim_rn_rename_core;

  localparam int NA = 16;
  localparam int NP = 32;
  localparam int AW = 4;
  localparam int TW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ren_valid_i = 1'b0;
  logic [AW-1:0]   ren_arch_i = '0;
  logic            ren_stall_o;
  logic [TW-1:0]   ren_new_tag_o, ren_prev_tag_o;
  logic [2*AW-1:0] src_arch_i = '0;
  logic [2*TW-1:0] src_tag_o;
  logic            rel_valid_i = 1'b0;
  logic [TW-1:0]   rel_tag_i = '0;

  always #2 clk = ~clk;

  rn_rename_core #(.NUM_ARCH(NA), .NUM_PHYS(NP), .ZERO_ARCH(0), .NUM_SRC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ren_valid_i(ren_valid_i), .ren_arch_i(ren_arch_i),
    .ren_stall_o(ren_stall_o), .ren_new_tag_o(ren_new_tag_o), .ren_prev_tag_o(ren_prev_tag_o),
    .src_arch_i(src_arch_i), .src_tag_o(src_tag_o), .rel_valid_i(rel_valid_i), .rel_tag_i(rel_tag_i)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int map_m [NA];
  int fl_m [$];
  int retired [$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock of stimulus, with the model's expectations compared mid-cycle.
  task automatic step(input bit rv, input int ra, input bit lv, input int lt,
                      input int s0, input int s1, input string req);
    bit e_stall;
    int e_new, e_prev;
    @(negedge clk);
    ren_valid_i = rv; ren_arch_i = AW'(ra);
    rel_valid_i = lv; rel_tag_i = TW'(lt);
    src_arch_i = {AW'(s1), AW'(s0)};
    #1;
    e_stall = rv && ra != 0 && fl_m.size() == 0;
    e_prev  = map_m[ra];
    e_new   = (ra == 0) ? map_m[0] : (fl_m.size() > 0 ? fl_m[0] : -1);
    chk(req, "stall", int'(ren_stall_o), int'(e_stall));
    chk(req, "src0", int'(src_tag_o[TW-1:0]), map_m[s0]);
    chk(req, "src1", int'(src_tag_o[2*TW-1:TW]), map_m[s1]);
    if (rv) begin
      chk(req, "prev_tag", int'(ren_prev_tag_o), e_prev);
      if (!e_stall) chk(req, "new_tag", int'(ren_new_tag_o), e_new);
    end
    if (rv && ra != 0 && !e_stall) begin
      void'(fl_m.pop_front());
      map_m[ra] = e_new;
      retired.push_back(e_prev);
    end
    if (lv && lt != 0) fl_m.push_back(lt);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    for (int i = 0; i < NA; i++) map_m[i] = i;
    for (int t = NA; t < NP; t++) fl_m.push_back(t);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: identity mapping after reset
    for (int i = 0; i < NA; i += 2) step(0, 0, 0, 0, i, i + 1, "R1");

    // R2 / R3 / R8: rename 1..15, looking up the same register in the same cycle
    for (int a = 1; a < NA; a++) step(1, a, 0, 0, a, a - 1, "R8");
    for (int i = 0; i < NA; i += 2) step(0, 0, 0, 0, i, i + 1, "R3");

    // R4: zero register consumes nothing; next rename gets tag 31
    step(1, 0, 0, 0, 0, 4, "R4");
    step(1, 4, 0, 0, 4, 0, "R2");
    step(0, 0, 0, 0, 4, 0, "R3");

    // R5: empty list stalls; a release in the same cycle does not lift it
    step(1, 5, 0, 0, 5, 6, "R5");
    step(1, 5, 1, retired.pop_front(), 5, 6, "R5");
    step(0, 0, 0, 0, 5, 6, "R5");

    // R7: releasing the zero tag is ignored
    step(0, 0, 1, 0, 5, 6, "R7");
    // R6: the released tag comes back; then the list is empty again
    step(1, 5, 0, 0, 5, 6, "R6");
    step(1, 6, 0, 0, 5, 6, "R7");

    // R10: zero register with an empty list
    step(1, 0, 0, 0, 0, 1, "R10");

    // R6: FIFO order of several releases
    for (int k = 0; k < 3; k++) step(0, 0, 1, retired.pop_front(), 1, 2, "R6");
    for (int k = 0; k < 3; k++) step(1, 7 + k, 0, 0, 7 + k, 2, "R6");

    // R9: rename and release together keep the occupancy
    step(0, 0, 1, retired.pop_front(), 0, 1, "R9");
    for (int k = 0; k < 6; k++) step(1, 10 + (k % 5), 1, retired.pop_front(), 10, 11, "R9");
    step(1, 3, 0, 0, 3, 2, "R9");
    step(1, 2, 0, 0, 3, 2, "R9");

    // Mixed random traffic against the model
    lf = 32'h1ACE_B00C;
    for (int c = 0; c < 3000; c++) begin
      bit rv, lv;
      int lt;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      rv = lf[0] | lf[1];
      lv = (lf[2] | lf[3]) && retired.size() > 0;
      lt = lv ? retired.pop_front() : 0;
      if (lf[20:16] == 5'd0) begin lv = 1'b1; lt = 0; end
      step(rv, int'(lf[7:4]), lv, lt, int'(lf[11:8]), int'(lf[15:12]), "R9");
    end

    @(negedge clk);
    ren_valid_i = 1'b0; rel_valid_i = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule